// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialization Sequencer

This block keeps a DRAM array alive with CAS-before-RAS refresh, which relies on the device's own internal row counter, so no row address is driven. After reset it waits out the power-up pause. It then runs a fixed number of initialization refresh cycles and raises `init_done_o`. From then on it issues one refresh per interval, where the interval is the retention period divided by the row count. A parameter picks either the normal or the low-power retention period.

The block shares the RAS/CAS/WE strobes with an access controller through a request/grant handshake. While refreshes are pending it raises `req_o`. It drives the strobes only while `gnt_i` is high, and it drops the request once the precharge of the last pending cycle has ended.

If the grant is held off, refresh ticks pile up in a bounded pending count. When the grant arrives, the pending refreshes run back to back. A tick that finds the count already full is lost, and it sets a sticky error flag.

All strobe timings are whole clock cycles. Each one is derived from a nanosecond parameter as ceil(ns × CLK_MHZ / 1000), with a minimum of one cycle.

Top module: `dram_refresh_seq`

## Requirements
- R1: With LOW_POWER=0, refresh ticks occur every floor(RET_NORM_US × CLK_MHZ / ROWS) cycles once `init_done_o` is high. Each tick produces one refresh cycle, and in an uncontended steady state RAS falling edges are spaced by exactly that interval.
- R2: After reset is released, `req_o` stays low and `ras_n_o`/`cas_n_o` stay high for PAUSE_US × CLK_MHZ cycles. Then exactly INIT_CYCLES refresh cycles run. `init_done_o` rises one cycle after the last of their precharges ends, and interval ticks only start after that.
- R3: In each refresh cycle `cas_n_o` goes low CSR cycles before `ras_n_o` falls (CSR derived from T_CSR_NS). It stays low for CHR cycles after `ras_n_o` falls (CHR derived from T_CHR_NS).
- R4: `ras_n_o` stays low for max(RAS cycles from T_RAS_NS, CHR) cycles. Both strobes then stay high for the precharge, which lasts max(cycles from T_RP_NS, cycles from T_RC_NS minus RAS minus CSR) before `cas_n_o` may fall again.
- R5: `we_n_o` is high at every cycle, including the whole CAS setup and hold window.
- R6: `req_o` is high while a refresh is pending or a cycle is in progress. A cycle's CAS setup starts on the first clock edge at which `gnt_i` is sampled high with a refresh pending. Both strobes are high whenever no cycle is running.
- R7: Pending refreshes are issued back to back under one grant. Consecutive RAS falling edges in a burst are CSR + RAS + precharge cycles apart.
- R8: At most MAX_PEND refreshes are held pending. A tick that arrives when the count is full and no cycle is starting is dropped, and it sets `ovf_err_o`, which stays high until reset.
- R9: Asserting `rst_ni` (asynchronous, active low) clears the pending count, `ovf_err_o` and `init_done_o`, and restarts the whole power-up pause and initialization sequence.
- R10: With LOW_POWER=1 the tick interval is floor(RET_LP_US × CLK_MHZ / ROWS) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gnt_i | input | 1 | Strobe bus granted to the refresh sequencer |
| req_o | output | 1 | Strobe bus requested |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low (held high) |
| init_done_o | output | 1 | Initialization refresh cycles complete |
| ovf_err_o | output | 1 | Sticky pending-count overflow |

## Verification
The bench builds two instances at 125 MHz with ROWS=16, a 2 µs pause, MAX_PEND=3, and retention of 4 µs (normal) and 16 µs (low power). These values give tick intervals of 31 and 125 cycles and a 250-cycle pause. With them, the full power-up sequence, the steady-state spacing of both grades, an overflow after holding off the grant for about six ticks, the burst that follows, and a mid-run reset all fit in a few thousand cycles. A behavioural model tracks each instance's position within a refresh cycle, its pending count and its timers, and it is compared against every output on every clock.

// File: rtl/drf_pkg.sv
package drf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACT,
    ST_PRE
  } strobe_st_e;

  // Whole cycles covering a nanosecond minimum, never less than one.
  function automatic int ns_cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/drf_timer.sv
module drf_timer #(
  parameter int PAUSE_CYC = 25000,
  parameter int INT_CYC   = 1953
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_done_i,
  output logic pause_done_o,
  output logic load_init_o,
  output logic tick_o
);
  import drf_pkg::*;

  localparam int TW = $clog2(max2(PAUSE_CYC, INT_CYC) + 1);

  logic [TW-1:0] cnt_q;
  logic          pause_done_q;

  assign pause_done_o = pause_done_q;
  assign load_init_o  = !pause_done_q && (cnt_q == TW'(PAUSE_CYC - 1));
  assign tick_o       = init_done_i && (cnt_q == TW'(INT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      pause_done_q <= 1'b0;
    end else if (!pause_done_q) begin
      if (load_init_o) begin
        pause_done_q <= 1'b1;
        cnt_q        <= '0;
      end else begin
        cnt_q <= cnt_q + TW'(1);
      end
    end else if (init_done_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + TW'(1);
    end
  end

  // R2: the pause ends exactly once per reset
  a_r2_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_init_o |=> !load_init_o && pause_done_o);

  // R1: ticks are separated by at least one idle count
  a_r1_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && INT_CYC > 1) |=> !tick_o);

endmodule

// File: rtl/drf_queue.sv
module drf_queue #(
  parameter int INIT_CYCLES = 8,
  parameter int MAX_PEND    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_init_i,
  input  logic tick_i,
  input  logic start_i,
  output logic pend_nz_o,
  output logic ovf_o
);
  import drf_pkg::*;

  localparam int PW = $clog2(max2(INIT_CYCLES, MAX_PEND) + 1);

  logic [PW-1:0] pend_q;
  logic          ovf_q;
  logic          full;
  logic          drop;

  assign full      = (pend_q == PW'(MAX_PEND));
  assign drop      = tick_i && full && !start_i;
  assign pend_nz_o = (pend_q != '0);
  assign ovf_o     = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (load_init_i) begin
        pend_q <= PW'(INIT_CYCLES);
      end else if (!drop) begin
        pend_q <= pend_q + PW'(tick_i) - PW'(start_i);
      end
      if (drop) ovf_q <= 1'b1;
    end
  end

  // R8: overflow is sticky until reset
  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  // R6: a cycle only starts with something pending
  a_r6_start_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> pend_nz_o);

  // R8: a full count never grows
  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !load_init_i) |=> pend_q <= PW'(max2(INIT_CYCLES, MAX_PEND)));

endmodule

// File: rtl/drf_strobe.sv
module drf_strobe #(
  parameter int CSR_CYC = 2,
  parameter int CHR_CYC = 2,
  parameter int RAS_CYC = 8,
  parameter int RP_CYC  = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gnt_i,
  input  logic pend_nz_i,
  input  logic pause_done_i,
  output logic start_o,
  output logic req_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic init_done_o
);
  import drf_pkg::*;

  localparam int SW = $clog2(max2(max2(CSR_CYC, RAS_CYC), RP_CYC) + 1);

  strobe_st_e    st_q;
  logic [SW-1:0] cnt_q;
  logic          done_q;
  logic          at_end;

  always_comb begin
    case (st_q)
      ST_SETUP: at_end = (cnt_q == SW'(CSR_CYC - 1));
      ST_ACT:   at_end = (cnt_q == SW'(RAS_CYC - 1));
      ST_PRE:   at_end = (cnt_q == SW'(RP_CYC - 1));
      default:  at_end = 1'b0;
    endcase
  end

  assign start_o = pend_nz_i && gnt_i &&
                   ((st_q == ST_IDLE) || ((st_q == ST_PRE) && at_end));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (start_o) begin
        st_q  <= ST_SETUP;
        cnt_q <= '0;
      end else if (at_end) begin
        cnt_q <= '0;
        case (st_q)
          ST_SETUP: st_q <= ST_ACT;
          ST_ACT:   st_q <= ST_PRE;
          default:  st_q <= ST_IDLE;
        endcase
      end else if (st_q != ST_IDLE) begin
        cnt_q <= cnt_q + SW'(1);
      end
      if (pause_done_i && !pend_nz_i && st_q == ST_IDLE) done_q <= 1'b1;
    end
  end

  assign ras_n_o     = (st_q != ST_ACT);
  assign cas_n_o     = !((st_q == ST_SETUP) ||
                         ((st_q == ST_ACT) && (cnt_q < SW'(CHR_CYC))));
  assign we_n_o      = 1'b1;
  assign req_o       = (st_q != ST_IDLE) || pend_nz_i;
  assign init_done_o = done_q;

  // R3: CAS already low in the cycle before RAS falls
  a_r3_cas_leads_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));

  // R4: precharge begins with both strobes high
  a_r4_precharge_both_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> cas_n_o);

  // R6: strobes active only under grant
  a_r6_strobe_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !cas_n_o) |-> gnt_i);

  // R6: request held while strobes are active
  a_r6_req_while_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !cas_n_o) |-> req_o);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int CLK_MHZ     = 125,
  parameter int ROWS        = 2048,
  parameter int RET_NORM_US = 32000,
  parameter int RET_LP_US   = 128000,
  parameter bit LOW_POWER   = 1'b0,
  parameter int PAUSE_US    = 200,
  parameter int INIT_CYCLES = 8,
  parameter int MAX_PEND    = 8,
  parameter int T_CSR_NS    = 10,
  parameter int T_CHR_NS    = 10,
  parameter int T_RAS_NS    = 60,
  parameter int T_RP_NS     = 40,
  parameter int T_RC_NS     = 110
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gnt_i,
  output logic req_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic init_done_o,
  output logic ovf_err_o
);
  import drf_pkg::*;

  localparam int RET_US    = LOW_POWER ? RET_LP_US : RET_NORM_US;
  localparam int INT_CYC   = RET_US * CLK_MHZ / ROWS;
  localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int CSR_CYC   = ns_cyc(T_CSR_NS, CLK_MHZ);
  localparam int CHR_CYC   = ns_cyc(T_CHR_NS, CLK_MHZ);
  localparam int RAS_CYC   = max2(ns_cyc(T_RAS_NS, CLK_MHZ), CHR_CYC);
  localparam int RP_CYC    = max2(ns_cyc(T_RP_NS, CLK_MHZ),
                                  ns_cyc(T_RC_NS, CLK_MHZ) - RAS_CYC - CSR_CYC);

  logic pause_done, load_init, tick, start, pend_nz;

  drf_timer #(
    .PAUSE_CYC(PAUSE_CYC),
    .INT_CYC  (INT_CYC)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_done_i (init_done_o),
    .pause_done_o(pause_done),
    .load_init_o (load_init),
    .tick_o      (tick)
  );

  drf_queue #(
    .INIT_CYCLES(INIT_CYCLES),
    .MAX_PEND   (MAX_PEND)
  ) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_init_i(load_init),
    .tick_i     (tick),
    .start_i    (start),
    .pend_nz_o  (pend_nz),
    .ovf_o      (ovf_err_o)
  );

  drf_strobe #(
    .CSR_CYC(CSR_CYC),
    .CHR_CYC(CHR_CYC),
    .RAS_CYC(RAS_CYC),
    .RP_CYC (RP_CYC)
  ) u_strobe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gnt_i       (gnt_i),
    .pend_nz_i   (pend_nz),
    .pause_done_i(pause_done),
    .start_o     (start),
    .req_o       (req_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .we_n_o      (we_n_o),
    .init_done_o (init_done_o)
  );

  // R2: bus untouched during the power-up pause
  a_r2_quiet_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pause_done |-> (ras_n_o && cas_n_o && !req_o && !init_done_o));

  // R5: write enable high whenever CAS is low
  a_r5_we_high_cas_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n_o |-> we_n_o);

endmodule

// File: tb/tb_dram_refresh_seq.sv
`timescale 1ns/1ps

module drf_model #(
  parameter int INTV  = 31,
  parameter int PAUSE = 250,
  parameter int INIT  = 8,
  parameter int MAXP  = 3,
  parameter int CSR   = 2,
  parameter int CHR   = 2,
  parameter int RASC  = 8,
  parameter int LEN   = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt,
  output logic req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic init_done,
  output logic ovf
);
  int pt, pdone, ic, pend, pos, idn, ov;
  int load, tick, start, endc, dset, npend, npos;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pt = 0; pdone = 0; ic = 0; pend = 0; pos = -1; idn = 0; ov = 0;
    end else begin
      load  = (!pdone && pt == PAUSE - 1) ? 1 : 0;
      tick  = (idn != 0 && ic == INTV - 1) ? 1 : 0;
      endc  = (pos == LEN - 1) ? 1 : 0;
      start = (gnt && pend > 0 && (pos < 0 || endc != 0)) ? 1 : 0;
      dset  = (pdone != 0 && pend == 0 && pos < 0) ? 1 : 0;
      if (load != 0) npend = INIT;
      else if (tick != 0 && pend == MAXP && start == 0) begin
        npend = pend; ov = 1;
      end else npend = pend + tick - start;
      if (start != 0) npos = 0;
      else if (pos >= 0 && endc == 0) npos = pos + 1;
      else npos = -1;
      if (pdone == 0) begin
        if (load != 0) pdone = 1; else pt = pt + 1;
      end
      ic   = (idn != 0) ? ((tick != 0) ? 0 : ic + 1) : 0;
      idn  = idn | dset;
      pend = npend;
      pos  = npos;
    end
  end

  always_comb begin
    ras_n     = !(pos >= CSR && pos < CSR + RASC);
    cas_n     = !(pos >= 0 && pos < CSR + CHR);
    we_n      = 1'b1;
    req       = (pos >= 0) || (pend > 0);
    init_done = (idn != 0);
    ovf       = (ov != 0);
  end
endmodule

module tb_dram_refresh_seq;
  localparam int MHZ   = 125;
  localparam int CSR   = (10 * MHZ + 999) / 1000;
  localparam int CHR   = (10 * MHZ + 999) / 1000;
  localparam int RASC  = (60 * MHZ + 999) / 1000;
  localparam int RPB   = (40 * MHZ + 999) / 1000;
  localparam int RCC   = (110 * MHZ + 999) / 1000;
  localparam int RPC   = (RPB > RCC - RASC - CSR) ? RPB : RCC - RASC - CSR;
  localparam int LEN   = CSR + RASC + RPC;
  localparam int INT_N = 4 * MHZ / 16;
  localparam int INT_L = 16 * MHZ / 16;
  localparam int PAUSE = 2 * MHZ;

  logic clk = 1'b0;
  logic rst_n;
  logic gnt_n = 1'b0, gnt_l = 1'b0;
  logic block = 1'b0;
  logic req_n, ras_n_n, cas_n_n, we_n_n, id_n, ovf_n;
  logic req_l, ras_n_l, cas_n_l, we_n_l, id_l, ovf_l;
  logic m_req_n, m_ras_n, m_cas_n, m_we_n, m_id_n, m_ovf_n;
  logic m_req_l, m_ras_l, m_cas_l, m_we_l, m_id_l, m_ovf_l;

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_en = 0, chk_int = 0, chk_lp = 0, burst = 0;

  always #4 clk = ~clk;

  dram_refresh_seq #(
    .CLK_MHZ(MHZ), .ROWS(16), .RET_NORM_US(4), .RET_LP_US(16), .LOW_POWER(1'b0),
    .PAUSE_US(2), .INIT_CYCLES(8), .MAX_PEND(3)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt_n), .req_o(req_n), .ras_n_o(ras_n_n),
    .cas_n_o(cas_n_n), .we_n_o(we_n_n), .init_done_o(id_n), .ovf_err_o(ovf_n)
  );

  dram_refresh_seq #(
    .CLK_MHZ(MHZ), .ROWS(16), .RET_NORM_US(4), .RET_LP_US(16), .LOW_POWER(1'b1),
    .PAUSE_US(2), .INIT_CYCLES(8), .MAX_PEND(3)
  ) dut_lp (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt_l), .req_o(req_l), .ras_n_o(ras_n_l),
    .cas_n_o(cas_n_l), .we_n_o(we_n_l), .init_done_o(id_l), .ovf_err_o(ovf_l)
  );

  drf_model #(.INTV(INT_N), .PAUSE(PAUSE), .INIT(8), .MAXP(3), .CSR(CSR), .CHR(CHR),
              .RASC(RASC), .LEN(LEN)) mdl_n (
    .clk(clk), .rst_n(rst_n), .gnt(gnt_n), .req(m_req_n), .ras_n(m_ras_n),
    .cas_n(m_cas_n), .we_n(m_we_n), .init_done(m_id_n), .ovf(m_ovf_n));

  drf_model #(.INTV(INT_L), .PAUSE(PAUSE), .INIT(8), .MAXP(3), .CSR(CSR), .CHR(CHR),
              .RASC(RASC), .LEN(LEN)) mdl_l (
    .clk(clk), .rst_n(rst_n), .gnt(gnt_l), .req(m_req_l), .ras_n(m_ras_l),
    .cas_n(m_cas_l), .we_n(m_we_l), .init_done(m_id_l), .ovf(m_ovf_l));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // arbiter: grant follows request; block only withholds a new grant
  always @(negedge clk) begin
    gnt_n <= rst_n && req_n && (gnt_n || !block);
    gnt_l <= rst_n && req_l;
  end

  // per-clock comparison against the model
  always @(negedge clk) if (cmp_en) begin
    chk("R3", "cas_n", cas_n_n, m_cas_n);
    chk("R4", "ras_n", ras_n_n, m_ras_n);
    chk("R5", "we_n", we_n_n, m_we_n);
    chk("R6", "req", req_n, m_req_n);
    chk("R2", "init_done", id_n, m_id_n);
    chk("R8", "ovf_err", ovf_n, m_ovf_n);
    chk("R10", "lp cas_n", cas_n_l, m_cas_l);
    chk("R10", "lp ras_n", ras_n_l, m_ras_l);
    chk("R5", "lp we_n", we_n_l, m_we_l);
    chk("R10", "lp req", req_l, m_req_l);
    chk("R10", "lp init_done", id_l, m_id_l);
    chk("R10", "lp ovf_err", ovf_l, m_ovf_l);
  end

  // edge monitors: intervals, init count, burst spacing
  logic prev_ras_n = 1'b1, prev_ras_l = 1'b1, prev_id = 1'b0;
  int last_n = -1, last_l = -1, init_cnt = 0, bcount = 0;
  int gaps_n = 0, gaps_l = 0, bgaps = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras_n <= 1'b1; prev_ras_l <= 1'b1; prev_id <= 1'b0;
      init_cnt <= 0; last_n <= -1; last_l <= -1;
    end else begin
      prev_ras_n <= ras_n_n;
      prev_ras_l <= ras_n_l;
      prev_id    <= id_n;
      if (prev_ras_n && !ras_n_n) begin
        if (!id_n) init_cnt <= init_cnt + 1;
        if (chk_int && last_n >= 0) begin
          chk("R1", "tick spacing", cyc - last_n, INT_N);
          gaps_n <= gaps_n + 1;
        end
        if (burst) begin
          bcount <= bcount + 1;
          if (bcount >= 1 && bcount <= 2) begin
            chk("R7", "burst spacing", cyc - last_n, LEN);
            bgaps <= bgaps + 1;
          end
        end
        last_n <= cyc;
      end
      if (prev_ras_l && !ras_n_l) begin
        if (chk_lp && last_l >= 0) begin
          chk("R10", "lp tick spacing", cyc - last_l, INT_L);
          gaps_l <= gaps_l + 1;
        end
        last_l <= cyc;
      end
      if (!prev_id && id_n) chk("R2", "init refresh count", init_cnt, 8);
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("WDOG", "watchdog expired", 1, 0);
    summary();
  end

  initial begin
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    cmp_en = 1;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "reset req", req_n, 0);
    chk("R9", "reset ras_n", ras_n_n, 1);
    chk("R9", "reset cas_n", cas_n_n, 1);
    chk("R9", "reset init_done", id_n, 0);
    chk("R9", "reset ovf", ovf_n, 0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    chk("R2", "pause quiet req", req_n, 0);
    chk("R2", "pause quiet ras_n", ras_n_n, 1);
    repeat (400) @(negedge clk);
    chk("R2", "init_done after init", id_n, 1);
    chk_int = 1;
    repeat (200) @(negedge clk);
    chk_lp = 1;
    repeat (450) @(negedge clk);
    chk_int = 0; chk_lp = 0;
    chk("R1", "normal gaps seen", (gaps_n >= 3) ? 1 : 0, 1);
    chk("R10", "lp gaps seen", (gaps_l >= 1) ? 1 : 0, 1);
    // R8: withhold grant until the pending count overflows
    while (req_n) @(negedge clk);
    block = 1;
    repeat (200) @(negedge clk);
    chk("R8", "overflow flagged", ovf_n, 1);
    chk("R8", "lp no overflow", ovf_l, 0);
    chk("R6", "request held while blocked", req_n, 1);
    bcount = 0;
    burst = 1;
    block = 0;
    repeat (150) @(negedge clk);
    burst = 0;
    chk("R7", "burst gaps seen", bgaps, 2);
    chk("R8", "overflow still set", ovf_n, 1);
    // R9: mid-run reset restarts everything
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9", "reset clears ovf", ovf_n, 0);
    chk("R9", "reset clears init_done", id_n, 0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    chk("R9", "restart pause req", req_n, 0);
    chk("R9", "restart pause init_done", id_n, 0);
    repeat (500) @(negedge clk);
    chk("R9", "restart init_done", id_n, 1);
    chk("R9", "restart lp init_done", id_l, 1);
    summary();
  end
endmodule